// File: doc/BRIEF.md
# Receive Buffer Packet Store Controller

The block sits between a receive MAC byte stream and a host reader and places accepted frames into a circular byte buffer. Each frame arrives as a start pulse, a run of valid bytes and an end pulse. The end pulse carries the CRC and alignment verdicts. The address-filter decision is sampled with the start pulse. Frames that fail the filter are ignored completely. For an accepted frame, four header bytes are reserved at the committed write pointer and data bytes are written behind them. The final four bytes of the frame are held back in a short delay line, so the CRC field never reaches the buffer.

At end of frame the block decides whether to keep or drop the frame. A clean frame is kept: its header is written in a single cycle, the committed write pointer advances past it, and a packet-received pulse is raised. A flawed frame (CRC error, alignment fragment or short length) is dropped unless the keep-bad-frames mode is set. A frame that runs out of space is always dropped. A dropped frame leaves the committed pointer unchanged, so its space is reused and older packets are untouched.

The host pulls bytes one at a time through a read strobe. It sees the buffer as empty once its pointer reaches the committed write pointer. Each error source produces a one-cycle event bit, gated by its own interrupt enable. Reading while empty is also reported as one of these events.

Top module: `rxbuf_store`

## Requirements
- R1: The last four bytes of every frame are never written to the buffer; the header byte count equals frame length minus four.
- R2: Each kept packet is laid out as a status byte, a zero byte, the byte count low byte, then the byte count high byte, followed by the data bytes in arrival order. Status bit 0 is CRC error, bit 1 is alignment error, bit 2 is short frame, and the other bits are zero.
- R3: A frame whose rx_addr_ok_i is low at its start pulse stores nothing, raises no event and leaves buf_empty_o unchanged.
- R4: With diag_keep_bad_i low, a frame with a CRC error, an alignment error or fewer than 64 bytes (CRC included) is dropped. The write pointer returns to the frame start, so the next kept packet follows the last kept one directly. err_evt_o bit 0, 1 or 2 pulses for the matching error one cycle after the end pulse.
- R5: With diag_keep_bad_i high, a flawed frame that fits is kept, and its error bits appear in the header status byte.
- R6: When the next data or header byte would land on the host read address, the frame is dropped, err_evt_o bit 3 pulses, no packet-received pulse occurs, and previously kept packets read back intact.
- R7: A kept frame gives a one-cycle pkt_rcvd_o pulse one cycle after the end pulse, deasserts buf_empty_o in that same cycle, and drives pkt_irq_o as pkt_rcvd_o ANDed with pkt_irq_en_i.
- R8: A host read strobe on a non-empty buffer returns the next byte on host_data_o one cycle later. buf_empty_o rises again when the reader catches up with the committed write pointer.
- R9: A host read strobe while buf_empty_o is high pulses err_evt_o bit 4 one cycle later and does not move the read pointer.
- R10: err_irq_o equals err_evt_o ANDed bit-wise with err_irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sof_i | input | 1 | Start-of-frame pulse, no data in that cycle |
| rx_addr_ok_i | input | 1 | Address filter accept, sampled with rx_sof_i |
| rx_vld_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_eof_i | input | 1 | End-of-frame pulse, no data in that cycle |
| rx_crc_err_i | input | 1 | CRC error, qualified by rx_eof_i |
| rx_align_err_i | input | 1 | Leftover bit fragment, qualified by rx_eof_i |
| diag_keep_bad_i | input | 1 | Keep flawed frames |
| host_rd_i | input | 1 | Host read strobe |
| host_data_o | output | 8 | Byte returned one cycle after the strobe |
| buf_empty_o | output | 1 | No unread committed bytes |
| pkt_rcvd_o | output | 1 | One-cycle pulse per kept packet |
| pkt_irq_en_i | input | 1 | Packet interrupt enable |
| pkt_irq_o | output | 1 | Packet interrupt |
| err_evt_o | output | 5 | Error pulses: 0 CRC, 1 align, 2 short, 3 overflow, 4 empty read |
| err_irq_en_i | input | 5 | Per-error interrupt enable |
| err_irq_o | output | 5 | Per-error interrupt |

## Verification
The end-of-frame commit and a host read can fall on the same clock edge, because the committed write pointer and the read pointer are updated by different pieces of logic. The bench provokes this twice by forking a read strobe onto the exact cycle of the end pulse. In the first case an older packet is pending; that read must return the older packet's first header byte, and the new packet must follow intact. In the second case the buffer is empty; the read must give an empty-read event in the same cycle as the packet-received pulse, while the new packet still reads back completely.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;
  localparam int NUM_EVT   = 5;
  localparam int EVT_CRC   = 0;
  localparam int EVT_ALIGN = 1;
  localparam int EVT_SHORT = 2;
  localparam int EVT_OVF   = 3;
  localparam int EVT_RDEMP = 4;

  typedef struct packed {
    logic ovf;
    logic short_frm;
    logic align;
    logic crc;
  } frame_evt_t;
endpackage

// File: rtl/rxbuf_tail_strip.sv
module rxbuf_tail_strip #(
  parameter int TAIL = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] data_i,
  output logic       vld_o,
  output logic [7:0] data_o
);
  localparam int CW = $clog2(TAIL + 1);

  logic [7:0]    pipe_q [TAIL];
  logic [CW-1:0] fill_q;

  // a byte leaves only once TAIL newer bytes exist behind it
  assign vld_o  = vld_i && (fill_q == CW'(TAIL));
  assign data_o = pipe_q[TAIL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < TAIL; i++) pipe_q[i] <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (vld_i) begin
      pipe_q[0] <= data_i;
      for (int i = 1; i < TAIL; i++) pipe_q[i] <= pipe_q[i-1];
      if (fill_q != CW'(TAIL)) fill_q <= fill_q + CW'(1);
    end
  end
endmodule

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
  parameter int DEPTH = 128,
  parameter int HDR   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           dwe_i,
  input  logic [AW-1:0]  dwaddr_i,
  input  logic [7:0]     dwdata_i,
  input  logic           hwe_i,
  input  logic [AW-1:0]  hbase_i,
  input  logic [8*HDR-1:0] hdata_i,
  input  logic [AW-1:0]  raddr_i,
  output logic [7:0]     rdata_o
);
  logic [7:0] mem_q [DEPTH];

  assign rdata_o = mem_q[raddr_i];

  // data and header writes never overlap: header slots precede the data
  always_ff @(posedge clk_i) begin
    if (dwe_i) mem_q[dwaddr_i] <= dwdata_i;
    if (hwe_i) begin
      for (int i = 0; i < HDR; i++) mem_q[hbase_i + AW'(i)] <= hdata_i[8*i +: 8];
    end
  end
endmodule

// File: rtl/rxbuf_host_rd.sv
module rxbuf_host_rd #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [7:0]    mem_data_i,
  output logic [AW-1:0] rd_ptr_o,
  output logic          empty_o,
  output logic [7:0]    rd_data_o,
  output logic          rd_err_o
);
  logic [AW-1:0] rd_ptr_q;

  assign rd_ptr_o = rd_ptr_q;
  assign empty_o  = (rd_ptr_q == wr_ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q  <= '0;
      rd_data_o <= '0;
      rd_err_o  <= 1'b0;
    end else begin
      rd_err_o <= rd_i && empty_o;
      if (rd_i && !empty_o) begin
        rd_data_o <= mem_data_i;
        rd_ptr_q  <= rd_ptr_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/rxbuf_frame_ctl.sv
module rxbuf_frame_ctl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int MIN_FRAME = 64,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sof_i,
  input  logic                   addr_ok_i,
  input  logic                   raw_vld_i,
  input  logic                   eof_i,
  input  logic                   crc_err_i,
  input  logic                   align_err_i,
  input  logic                   keep_bad_i,
  input  logic                   s_vld_i,
  input  logic [7:0]             s_data_i,
  input  logic [AW-1:0]          rd_ptr_i,
  output logic                   in_frame_o,
  output logic [AW-1:0]          wr_ptr_o,
  output logic                   dwe_o,
  output logic [AW-1:0]          dwaddr_o,
  output logic [7:0]             dwdata_o,
  output logic                   hwe_o,
  output logic [8*HDR_BYTES-1:0] hdata_o,
  output logic                   pkt_done_o,
  output frame_evt_t             evt_o
);
  logic          in_frame_q, ovf_q;
  logic [15:0]   tot_q, stored_q;
  logic [AW-1:0] wr_ptr_q, free;
  logic          room_hit, eof_act, short_frm, ovf_fin, keep;
  logic [7:0]    status;

  // writable bytes with one slot left open so full never looks empty
  assign free     = rd_ptr_i - wr_ptr_q - AW'(1);
  assign room_hit = (32'(stored_q) + 32'(HDR_BYTES)) >= 32'(free);

  assign dwe_o    = in_frame_q && s_vld_i && !ovf_q && !room_hit;
  assign dwaddr_o = wr_ptr_q + AW'(HDR_BYTES) + stored_q[AW-1:0];
  assign dwdata_o = s_data_i;

  assign eof_act   = in_frame_q && eof_i;
  assign short_frm = tot_q < 16'(MIN_FRAME);
  assign ovf_fin   = ovf_q || (32'(free) < 32'(HDR_BYTES));
  assign keep      = !ovf_fin && (keep_bad_i || !(crc_err_i || align_err_i || short_frm));
  assign status    = {5'b0, short_frm, align_err_i, crc_err_i};

  assign hwe_o      = eof_act && keep;
  assign hdata_o    = {stored_q[15:8], stored_q[7:0], 8'h00, status};
  assign wr_ptr_o   = wr_ptr_q;
  assign in_frame_o = in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      ovf_q      <= 1'b0;
      tot_q      <= '0;
      stored_q   <= '0;
      wr_ptr_q   <= '0;
      pkt_done_o <= 1'b0;
      evt_o      <= '0;
    end else begin
      pkt_done_o <= eof_act && keep;
      evt_o      <= eof_act ? frame_evt_t'{ovf_fin, short_frm, align_err_i, crc_err_i}
                            : frame_evt_t'('0);
      if (sof_i) begin
        in_frame_q <= addr_ok_i;
        ovf_q      <= 1'b0;
        tot_q      <= '0;
        stored_q   <= '0;
      end else if (eof_act) begin
        in_frame_q <= 1'b0;
        if (keep) wr_ptr_q <= wr_ptr_q + AW'(HDR_BYTES) + stored_q[AW-1:0];
      end else if (in_frame_q) begin
        if (raw_vld_i && tot_q != '1) tot_q <= tot_q + 16'd1;
        if (s_vld_i && !ovf_q) begin
          if (room_hit) ovf_q    <= 1'b1;
          else          stored_q <= stored_q + 16'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int MIN_FRAME = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_sof_i,
  input  logic               rx_addr_ok_i,
  input  logic               rx_vld_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_eof_i,
  input  logic               rx_crc_err_i,
  input  logic               rx_align_err_i,
  input  logic               diag_keep_bad_i,
  input  logic               host_rd_i,
  output logic [7:0]         host_data_o,
  output logic               buf_empty_o,
  output logic               pkt_rcvd_o,
  input  logic               pkt_irq_en_i,
  output logic               pkt_irq_o,
  output logic [NUM_EVT-1:0] err_evt_o,
  input  logic [NUM_EVT-1:0] err_irq_en_i,
  output logic [NUM_EVT-1:0] err_irq_o
);
  localparam int AW = $clog2(DEPTH);

  logic                   in_frame, s_vld, dwe, hwe, rd_err;
  logic [7:0]             s_data, dwdata, mem_rdata;
  logic [AW-1:0]          wr_ptr, rd_ptr, dwaddr;
  logic [8*HDR_BYTES-1:0] hdata;
  frame_evt_t             fevt;

  rxbuf_tail_strip #(.TAIL(CRC_BYTES)) u_strip (
    .clk_i, .rst_ni,
    .clr_i  (rx_sof_i),
    .vld_i  (rx_vld_i && in_frame),
    .data_i (rx_data_i),
    .vld_o  (s_vld),
    .data_o (s_data)
  );

  rxbuf_frame_ctl #(.DEPTH(DEPTH), .MIN_FRAME(MIN_FRAME)) u_ctl (
    .clk_i, .rst_ni,
    .sof_i       (rx_sof_i),
    .addr_ok_i   (rx_addr_ok_i),
    .raw_vld_i   (rx_vld_i),
    .eof_i       (rx_eof_i),
    .crc_err_i   (rx_crc_err_i),
    .align_err_i (rx_align_err_i),
    .keep_bad_i  (diag_keep_bad_i),
    .s_vld_i     (s_vld),
    .s_data_i    (s_data),
    .rd_ptr_i    (rd_ptr),
    .in_frame_o  (in_frame),
    .wr_ptr_o    (wr_ptr),
    .dwe_o       (dwe),
    .dwaddr_o    (dwaddr),
    .dwdata_o    (dwdata),
    .hwe_o       (hwe),
    .hdata_o     (hdata),
    .pkt_done_o  (pkt_rcvd_o),
    .evt_o       (fevt)
  );

  rxbuf_mem #(.DEPTH(DEPTH), .HDR(HDR_BYTES)) u_mem (
    .clk_i,
    .dwe_i    (dwe),
    .dwaddr_i (dwaddr),
    .dwdata_i (dwdata),
    .hwe_i    (hwe),
    .hbase_i  (wr_ptr),
    .hdata_i  (hdata),
    .raddr_i  (rd_ptr),
    .rdata_o  (mem_rdata)
  );

  rxbuf_host_rd #(.AW(AW)) u_host (
    .clk_i, .rst_ni,
    .rd_i       (host_rd_i),
    .wr_ptr_i   (wr_ptr),
    .mem_data_i (mem_rdata),
    .rd_ptr_o   (rd_ptr),
    .empty_o    (buf_empty_o),
    .rd_data_o  (host_data_o),
    .rd_err_o   (rd_err)
  );

  assign err_evt_o = {rd_err, fevt};
  assign err_irq_o = err_evt_o & err_irq_en_i;
  assign pkt_irq_o = pkt_rcvd_o && pkt_irq_en_i;
endmodule

// File: rtl/rxbuf_store_chk.sv
module rxbuf_store_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_rd_i,
  input logic       buf_empty_o,
  input logic       pkt_rcvd_o,
  input logic       diag_keep_bad_i,
  input logic [4:0] err_evt_o
);
  AST_RDERR_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && buf_empty_o |=> err_evt_o[4]); // R9
  AST_NO_RDERR_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !buf_empty_o |=> !err_evt_o[4]); // R8
  AST_EMPTY_FALLS_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_empty_o) |-> pkt_rcvd_o); // R7
  AST_COMMIT_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rcvd_o |-> !buf_empty_o); // R7
  AST_NO_OVERFLOW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_o[3] |-> !pkt_rcvd_o); // R6
  AST_FLAW_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_evt_o[2:0]) && !$past(diag_keep_bad_i) |-> !pkt_rcvd_o); // R4
endmodule

bind rxbuf_store rxbuf_store_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .host_rd_i       (host_rd_i),
  .buf_empty_o     (buf_empty_o),
  .pkt_rcvd_o      (pkt_rcvd_o),
  .diag_keep_bad_i (diag_keep_bad_i),
  .err_evt_o       (err_evt_o)
);

// File: tb/rxbuf_store_tb.sv
module rxbuf_store_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 0, addr_ok = 0, vld = 0, eof = 0, crc = 0, align = 0, diag = 0;
  logic [7:0] data = 0;
  logic       host_rd = 0;
  logic [7:0] host_data;
  logic       buf_empty, pkt_rcvd, pkt_irq_en = 1, pkt_irq;
  logic [4:0] err_evt, err_irq_en = 5'h1f, err_irq;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  logic       rd_fire = 0;

  always #5 clk = ~clk;

  rxbuf_store u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_sof_i(sof), .rx_addr_ok_i(addr_ok), .rx_vld_i(vld), .rx_data_i(data),
    .rx_eof_i(eof), .rx_crc_err_i(crc), .rx_align_err_i(align),
    .diag_keep_bad_i(diag), .host_rd_i(host_rd), .host_data_o(host_data),
    .buf_empty_o(buf_empty), .pkt_rcvd_o(pkt_rcvd), .pkt_irq_en_i(pkt_irq_en),
    .pkt_irq_o(pkt_irq), .err_evt_o(err_evt), .err_irq_en_i(err_irq_en),
    .err_irq_o(err_irq)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // monitor: every accepted host read pops one expected byte
  always @(posedge clk) rd_fire <= rst_n && host_rd && !buf_empty;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check(0, "R8 read with nothing expected", host_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(host_data == e, "R1 R2 R8 stored byte", host_data, e);
      end
    end
  end

  task automatic send_frame(input int len, input bit pass, input bit c_err, input bit a_err,
                            input bit ovf_exp, input logic [7:0] seed,
                            input logic [4:0] extra, input string tag);
    bit short_f, store;
    logic [4:0] exp_evt;
    short_f = len < 64;
    store   = pass && !ovf_exp && (diag || !(c_err || a_err || short_f));
    exp_evt = pass ? {1'b0, ovf_exp, short_f, a_err, c_err} : 5'b0;
    exp_evt = exp_evt | extra;
    if (store) begin
      exp_q.push_back({5'b0, short_f, a_err, c_err});
      exp_q.push_back(8'h00);
      exp_q.push_back(8'((len - 4) & 255));
      exp_q.push_back(8'((len - 4) >> 8));
      for (int i = 0; i < len - 4; i++) exp_q.push_back(seed + 8'(i));
    end
    @(negedge clk); sof = 1; addr_ok = pass;
    @(negedge clk); sof = 0; addr_ok = 0;
    for (int i = 0; i < len; i++) begin
      vld = 1; data = seed + 8'(i);
      @(negedge clk);
    end
    vld = 0; eof = 1; crc = c_err; align = a_err;
    @(negedge clk); eof = 0; crc = 0; align = 0;
    check(err_evt == exp_evt, {tag, " event bits"}, err_evt, exp_evt);
    check(pkt_rcvd == store, {tag, " R7 packet pulse"}, pkt_rcvd, store);
    check(pkt_irq == (store && pkt_irq_en), {tag, " R7 packet irq"}, pkt_irq, store && pkt_irq_en);
    check(err_irq == (exp_evt & err_irq_en), {tag, " R10 irq mask"}, err_irq, exp_evt & err_irq_en);
  endtask

  // strobe lands on the negedge that drives a frame's end pulse
  task automatic rd_pulse(input int wait_n);
    repeat (wait_n) @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (buf_empty) begin host_rd = 0; break; end
      host_rd = 1;
    end
    host_rd = 0;
    @(negedge clk);
    check(buf_empty == 1, {tag, " R8 empty after drain"}, buf_empty, 1);
    check(exp_q.size() == 0, {tag, " R8 all expected bytes read"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(buf_empty == 1, "reset empty", buf_empty, 1);
    check(pkt_rcvd == 0, "reset pkt", pkt_rcvd, 0);
    check(err_evt == 0, "reset events", err_evt, 0);

    // R9: read while empty
    rd_pulse(0);
    check(err_evt == 5'b10000, "R9 empty read event", err_evt, 5'b10000);
    check(err_irq == 5'b10000, "R10 empty read irq", err_irq, 5'b10000);

    send_frame(70, 1, 0, 0, 0, 8'h10, 5'b0, "R1 good");
    check(buf_empty == 0, "R7 not empty after commit", buf_empty, 0);
    drain("R1 good");

    send_frame(70, 0, 1, 0, 0, 8'h20, 5'b0, "R3 filtered");
    check(buf_empty == 1, "R3 still empty", buf_empty, 1);

    // R4: dropped frames then a good one must follow directly
    send_frame(70, 1, 1, 0, 0, 8'h30, 5'b0, "R4 crc drop");
    send_frame(40, 1, 0, 0, 0, 8'h40, 5'b0, "R4 short drop");
    send_frame(66, 1, 0, 1, 0, 8'h48, 5'b0, "R4 align drop");
    check(buf_empty == 1, "R4 nothing kept", buf_empty, 1);
    send_frame(64, 1, 0, 0, 0, 8'h50, 5'b0, "R4 good after drop");
    drain("R4");

    diag = 1;
    send_frame(70, 1, 0, 1, 0, 8'h60, 5'b0, "R5 align kept");
    send_frame(30, 1, 1, 0, 0, 8'h70, 5'b0, "R5 short crc kept");
    diag = 0;
    drain("R5");

    send_frame(64, 1, 0, 0, 0, 8'h80, 5'b0, "R6 first");
    send_frame(100, 1, 0, 0, 1, 8'h90, 5'b0, "R6 overflow");
    drain("R6 intact");

    err_irq_en = 5'b10000; pkt_irq_en = 0;
    send_frame(70, 1, 1, 0, 0, 8'ha0, 5'b0, "R10 masked crc");
    send_frame(64, 1, 0, 0, 0, 8'hb0, 5'b0, "R7 irq disabled");
    drain("R10");
    err_irq_en = 5'h1f; pkt_irq_en = 1;

    // commit and host read on the same edge, older packet pending
    diag = 1;
    send_frame(20, 1, 0, 0, 0, 8'hc0, 5'b0, "R8 pending");
    diag = 0;
    fork
      send_frame(64, 1, 0, 0, 0, 8'hd0, 5'b0, "R8 commit with read");
      rd_pulse(66);
    join
    drain("R8 concurrent");

    // commit and empty read on the same edge
    fork
      send_frame(64, 1, 0, 0, 0, 8'he0, 5'b10000, "R9 commit with empty read");
      rd_pulse(66);
    join
    check(buf_empty == 0, "R9 commit visible", buf_empty, 0);
    drain("R9 concurrent");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule